// File: doc/BRIEF.md
# SPI Bit Clock Generator with Selectable Divider Paths

This block turns a fast source clock into the serial clock of an SPI controller. It also produces the two single-cycle strobes that the data shifter needs: one that says "drive the next output bit now" and one that says "capture the input bit now". Two divider paths exist side by side, and one configuration bit picks which one drives the bit rate. The first path is a coarse power-of-two divider behind a fixed divide-by-4 stage. The second is a fine linear divider behind a fixed divide-by-2 stage.

A transfer engine raises `run_i` to start serial clocking and keeps it high for as long as more bits are wanted. The divider fields, the path select, the clock polarity and the clock phase are captured once, at the start of a run. While a run is in progress they are not looked at. When `run_i` falls, the bit in flight is completed before the clock parks at its idle level. While idle, the clock follows the polarity input.

Top module: `sck_rate_gen`

## Requirements
- R1: With `path_sel_i`=0, the SCK period is 4·2^E source cycles, where E is `pow_exp_i`. Each SCK level therefore lasts 2·2^E cycles.
- R2: With `path_sel_i`=1, the SCK period is 2·(L+1) source cycles, where L is `lin_div_i` (0..255). Each SCK level therefore lasts L+1 cycles.
- R3: On the power-of-two path, E = 0, 1, 2 and 3 give full SCK periods of 4, 8, 16 and 32 source cycles.
- R4: A run starts on the first rising clock edge that samples `run_i` high while idle. SCK holds its idle level through the first half bit. The first SCK edge appears exactly one half period (R1/R2) after that start edge.
- R5: During reset SCK, `shift_o` and `sample_o` are 0, and reset acts at once, even mid-transfer. While idle, SCK takes the value that `cpol_i` had one clock earlier, and both strobes stay low.
- R6: A strobe is high for exactly the cycle in which SCK changes, and never at the same time as the other strobe. The leading edge is the edge leaving the idle level. With the latched phase = 0, the leading edge carries `sample_o` and the trailing edge carries `shift_o`. With phase = 1 the two are swapped. No strobe fires without an SCK edge.
- R7: Once `run_i` is seen low, the block finishes the current bit: it stops on the next trailing edge, so SCK ends at the idle level. A run lasting B bits produces exactly 2·B SCK edges, with no gap between consecutive bits.
- R8: Changes to `path_sel_i`, `pow_exp_i`, `lin_div_i`, `cpol_i` or `cpha_i` while a run is in progress do not alter the SCK timing, the levels or the strobe assignment of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Keep clocking bits while high |
| path_sel_i | input | 1 | 0: power-of-two path, 1: linear path |
| pow_exp_i | input | POW_W | Exponent E of the power-of-two path |
| lin_div_i | input | LIN_W | Divisor field L of the linear path |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Clock phase: selects which edge samples |
| sck_o | output | 1 | Serial clock |
| shift_o | output | 1 | One-cycle pulse: drive the next output bit |
| sample_o | output | 1 | One-cycle pulse: capture the input bit |

## Verification
A wrong count in either path shows up within one half period, as an SCK edge arriving early or late at the port. A wrong leading/trailing decision shows up at the very first edge of a run, as the wrong strobe or as SCK moving toward the idle level. A corrupted run/idle state shows up either as extra or missing edges after `run_i` falls, or as SCK failing to track the polarity input one cycle later while idle. Configuration that leaks into a run shows up as a changed edge spacing, because the bench scrambles every configuration input right after each start.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;

  typedef enum logic {
    SR_IDLE = 1'b0,
    SR_RUN  = 1'b1
  } sr_state_e;

  typedef enum logic {
    PATH_POW2 = 1'b0,
    PATH_LIN  = 1'b1
  } sr_path_e;

  // Width of the stage counter needed to reach 2^E - 1 for the largest E.
  function automatic int unsigned stage_width(input int unsigned exp_w);
    return (1 << exp_w) - 1;
  endfunction

endpackage

// File: rtl/sck_div_pow2.sv
// Power-of-two half-period timer: fixed /2 prescale times 2^E stage.
// tick_o fires on the last cycle of every half SCK period (2*2^E cycles).
module sck_div_pow2 #(
  parameter int unsigned POW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [POW_W-1:0] exp_i,
  output logic             tick_o
);
  import sck_rate_pkg::*;

  localparam int unsigned STG_W = stage_width(POW_W);

  logic             pre_q, pre_d;
  logic [STG_W-1:0] stg_q, stg_d;
  logic [STG_W:0]   pow_val;
  logic [STG_W-1:0] stg_lim;
  logic             stg_wrap;

  always_comb begin
    pow_val  = (STG_W+1)'(1) << exp_i;
    stg_lim  = pow_val[STG_W-1:0] - STG_W'(1);
    stg_wrap = (stg_q == stg_lim);
    tick_o   = en_i & pre_q & stg_wrap;
  end

  always_comb begin
    pre_d = pre_q;
    stg_d = stg_q;
    if (!en_i) begin
      pre_d = 1'b0;
      stg_d = '0;
    end else begin
      pre_d = ~pre_q;
      if (pre_q) begin
        stg_d = stg_wrap ? '0 : stg_q + STG_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= 1'b0;
      stg_q <= '0;
    end else begin
      pre_q <= pre_d;
      stg_q <= stg_d;
    end
  end

endmodule

// File: rtl/sck_div_lin.sv
// Linear half-period timer: fixed /2 prescale folds into the half period,
// so each half SCK period lasts L+1 source cycles.
module sck_div_lin #(
  parameter int unsigned LIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LIN_W-1:0] div_i,
  output logic             tick_o
);

  logic [LIN_W-1:0] cnt_q, cnt_d;
  logic             at_lim;

  always_comb begin
    at_lim = (cnt_q == div_i);
    tick_o = en_i & at_lim;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (at_lim) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + LIN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sck_phase_fsm.sv
// Run/idle control, SCK level and edge strobes.
module sck_phase_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cpol_live_i,
  input  logic cpol_lat_i,
  input  logic cpha_lat_i,
  input  logic half_tick_i,
  output logic busy_o,
  output logic sck_o,
  output logic shift_o,
  output logic sample_o
);
  import sck_rate_pkg::*;

  sr_state_e state_q, state_d;
  logic      sck_q, sck_d;
  logic      shift_q, shift_d;
  logic      sample_q, sample_d;
  logic      leading;

  always_comb begin
    state_d  = state_q;
    sck_d    = sck_q;
    shift_d  = 1'b0;
    sample_d = 1'b0;
    leading  = (sck_q == cpol_lat_i);
    case (state_q)
      SR_IDLE: begin
        sck_d = cpol_live_i;
        if (run_i) begin
          state_d = SR_RUN;
        end
      end
      SR_RUN: begin
        if (half_tick_i) begin
          sck_d = ~sck_q;
          if (leading ^ cpha_lat_i) begin
            sample_d = 1'b1;
          end else begin
            shift_d = 1'b1;
          end
          if (!leading && !run_i) begin
            state_d = SR_IDLE;
          end
        end
      end
      default: state_d = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SR_IDLE;
      sck_q    <= 1'b0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sck_q    <= sck_d;
      shift_q  <= shift_d;
      sample_q <= sample_d;
    end
  end

  assign busy_o   = (state_q == SR_RUN);
  assign sck_o    = sck_q;
  assign shift_o  = shift_q;
  assign sample_o = sample_q;

endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen #(
  parameter int unsigned POW_W = 3,
  parameter int unsigned LIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             path_sel_i,
  input  logic [POW_W-1:0] pow_exp_i,
  input  logic [LIN_W-1:0] lin_div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic             sck_o,
  output logic             shift_o,
  output logic             sample_o
);
  import sck_rate_pkg::*;

  sr_path_e         sel_q, sel_d;
  logic [POW_W-1:0] exp_q, exp_d;
  logic [LIN_W-1:0] div_q, div_d;
  logic             cpol_q, cpol_d;
  logic             cpha_q, cpha_d;
  logic             busy;
  logic             cfg_ld;
  logic             pow_en, lin_en;
  logic             pow_tick, lin_tick, half_tick;

  // Settings are captured only while idle.
  assign cfg_ld = ~busy;

  always_comb begin
    sel_d  = sel_q;
    exp_d  = exp_q;
    div_d  = div_q;
    cpol_d = cpol_q;
    cpha_d = cpha_q;
    if (cfg_ld) begin
      sel_d  = sr_path_e'(path_sel_i);
      exp_d  = pow_exp_i;
      div_d  = lin_div_i;
      cpol_d = cpol_i;
      cpha_d = cpha_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= PATH_POW2;
      exp_q  <= '0;
      div_q  <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      exp_q  <= exp_d;
      div_q  <= div_d;
      cpol_q <= cpol_d;
      cpha_q <= cpha_d;
    end
  end

  // Only the chosen path counts; the other is held cleared.
  assign pow_en = busy & (sel_q == PATH_POW2);
  assign lin_en = busy & (sel_q == PATH_LIN);

  sck_div_pow2 #(.POW_W(POW_W)) u_pow2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pow_en),
    .exp_i  (exp_q),
    .tick_o (pow_tick)
  );

  sck_div_lin #(.LIN_W(LIN_W)) u_lin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (lin_en),
    .div_i  (div_q),
    .tick_o (lin_tick)
  );

  assign half_tick = (sel_q == PATH_LIN) ? lin_tick : pow_tick;

  sck_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .cpol_live_i (cpol_i),
    .cpol_lat_i  (cpol_q),
    .cpha_lat_i  (cpha_q),
    .half_tick_i (half_tick),
    .busy_o      (busy),
    .sck_o       (sck_o),
    .shift_o     (shift_o),
    .sample_o    (sample_o)
  );

endmodule

// File: rtl/sck_rate_chk.sv
module sck_rate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic busy_i,
  input logic cpol_lat_i,
  input logic sck_i,
  input logic shift_i,
  input logic sample_i
);

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && sample_i));

  p_strobe_on_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i || sample_i) |-> (sck_i != $past(sck_i)));

  p_shift_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> !shift_i);

  p_idle_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(busy_i)) |-> (sck_i == $past(cpol_i)));

  p_stop_trailing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(busy_i) && !busy_i) |->
      ((sck_i == cpol_lat_i) && (shift_i || sample_i)));

endmodule

bind sck_rate_gen sck_rate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpol_i     (cpol_i),
  .busy_i     (busy),
  .cpol_lat_i (cpol_q),
  .sck_i      (sck_o),
  .shift_i    (shift_o),
  .sample_i   (sample_o)
);

// File: tb/sck_rate_gen_tb.sv
`timescale 1ns/1ps
module sck_rate_gen_tb;

  localparam int POW_W = 3;
  localparam int LIN_W = 8;
  localparam int NVEC  = 10;

  // {sel, exp[2:0], div[7:0], cpol, cpha, bits[3:0]}
  localparam logic [17:0] VECS [NVEC] = '{
    {1'b0, 3'd0, 8'd0,   1'b0, 1'b0, 4'd2},
    {1'b0, 3'd1, 8'd0,   1'b1, 1'b0, 4'd1},
    {1'b0, 3'd2, 8'd0,   1'b0, 1'b1, 4'd2},
    {1'b0, 3'd3, 8'd0,   1'b1, 1'b1, 4'd1},
    {1'b0, 3'd7, 8'd0,   1'b0, 1'b0, 4'd1},
    {1'b1, 3'd0, 8'd0,   1'b0, 1'b0, 4'd3},
    {1'b1, 3'd0, 8'd0,   1'b1, 1'b1, 4'd2},
    {1'b1, 3'd0, 8'd4,   1'b0, 1'b1, 4'd2},
    {1'b1, 3'd0, 8'd255, 1'b1, 1'b0, 4'd1},
    {1'b1, 3'd0, 8'd2,   1'b0, 1'b0, 4'd4}
  };

  logic             clk_i;
  logic             rst_ni;
  logic             run_i;
  logic             path_sel_i;
  logic [POW_W-1:0] pow_exp_i;
  logic [LIN_W-1:0] lin_div_i;
  logic             cpol_i;
  logic             cpha_i;
  logic             sck_o;
  logic             shift_o;
  logic             sample_o;

  int errs;
  int checks;

  sck_rate_gen #(.POW_W(POW_W), .LIN_W(LIN_W)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .path_sel_i (path_sel_i),
    .pow_exp_i  (pow_exp_i),
    .lin_div_i  (lin_div_i),
    .cpol_i     (cpol_i),
    .cpha_i     (cpha_i),
    .sck_o      (sck_o),
    .shift_o    (shift_o),
    .sample_o   (sample_o)
  );

  initial clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [17:0] v);
    logic sel, cpol, cpha, prev, lead, exp_smp;
    logic [2:0] ex;
    logic [7:0] dv;
    int nb, h, ntog, ntrail, first_t, last_t, sp_bad, st_bad, limit;
    sel  = v[17]; ex = v[16:14]; dv = v[13:6];
    cpol = v[5];  cpha = v[4];   nb = int'(v[3:0]);
    h = sel ? (int'(dv) + 1) : (2 << ex);
    @(negedge clk_i);
    run_i = 1'b0; path_sel_i = sel; pow_exp_i = ex; lin_div_i = dv;
    cpol_i = cpol; cpha_i = cpha;
    repeat (2) @(negedge clk_i);
    prev = sck_o; run_i = 1'b1;
    ntog = 0; ntrail = 0; first_t = -1; last_t = 0; sp_bad = 0; st_bad = 0;
    limit = 1 + 2 * nb * h + 2 * h + 3;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk_i);
      if (c == 1) begin
        // scramble settings after the start edge (R8)
        path_sel_i = ~sel; pow_exp_i = ~ex; lin_div_i = ~dv; cpha_i = ~cpha;
      end
      if (sck_o != prev) begin
        ntog++;
        lead = (sck_o != cpol);
        if (ntog == 1) first_t = c;
        else if (c - last_t != h) sp_bad++;
        last_t = c;
        exp_smp = lead ^ cpha;
        if (sample_o != exp_smp || shift_o != !exp_smp) st_bad++;
        if (!lead) ntrail++;
      end else if (shift_o || sample_o) begin
        st_bad++;
      end
      prev = sck_o;
      if (ntrail >= nb - 1) run_i = 1'b0;
    end
    if (!sel && ex <= 3)
      chk(first_t == 1 + h, "R3/R4 first edge delay", first_t, 1 + h);
    else
      chk(first_t == 1 + h, "R4 first edge delay", first_t, 1 + h);
    if (sel) chk(sp_bad == 0, "R2/R8 half period spacing", sp_bad, 0);
    else     chk(sp_bad == 0, "R1/R8 half period spacing", sp_bad, 0);
    chk(ntog == 2 * nb, "R7 edge count", ntog, 2 * nb);
    chk(st_bad == 0, "R6 strobe placement", st_bad, 0);
    chk(sck_o == cpol, "R5 idle level after run", int'(sck_o), int'(cpol));
  endtask

  initial begin
    #4000000;
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    errs = 0; checks = 0;
    rst_ni = 1'b0; run_i = 1'b1; path_sel_i = 1'b0; pow_exp_i = '0;
    lin_div_i = '0; cpol_i = 1'b1; cpha_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(sck_o == 1'b0, "R5 sck in reset", int'(sck_o), 0);
    chk(!shift_o && !sample_o, "R5 strobes in reset", int'({shift_o, sample_o}), 0);
    run_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sck_o == 1'b1, "R5 idle follows cpol high", int'(sck_o), 1);
    cpol_i = 1'b0;
    @(negedge clk_i);
    chk(sck_o == 1'b0, "R5 idle follows cpol low", int'(sck_o), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // polarity latched at start: flip mid-run (R8)
    @(negedge clk_i);
    path_sel_i = 1'b1; lin_div_i = 8'd1; cpol_i = 1'b0; cpha_i = 1'b0; run_i = 1'b0;
    repeat (2) @(negedge clk_i);
    run_i = 1'b1;
    @(negedge clk_i);
    cpol_i = 1'b1; run_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(sck_o == 1'b1 && sample_o, "R8 leading edge uses latched polarity",
        int'({sck_o, sample_o}), 3);
    repeat (2) @(negedge clk_i);
    chk(sck_o == 1'b0 && shift_o, "R6 trailing edge shifts",
        int'({sck_o, shift_o}), 1);
    @(negedge clk_i);
    chk(sck_o == 1'b1, "R5 idle picks up new polarity", int'(sck_o), 1);

    // reset in mid-transfer acts at once (R5)
    path_sel_i = 1'b0; pow_exp_i = 3'd0; cpol_i = 1'b1; run_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(sck_o == 1'b0 && !shift_o && !sample_o, "R5 async reset mid-run",
        int'({sck_o, shift_o, sample_o}), 0);
    run_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(sck_o == 1'b1, "R5 idle after reset release", int'(sck_o), 1);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule